// File: doc/BRIEF.md
# Ones-Density Monitor and Enforcer

This block watches two serial bit streams, one heading out and one coming in, and checks each against a ones-density rule. The rule has two parts. A stream may not carry more than 15 zeros in a row. For every N from 1 to 23, every window of 8·(N+1) consecutive bits must hold at least N ones, so the longest window is 192 bits. Each stream is checked whenever its bit-valid strobe is high. A breach on either stream sets that stream's own sticky flag. The flag stays set until a clear pulse arrives.

When the enforce input is high, the block also repairs the outgoing stream. Before each bit is sent, it works out whether sending a 0 would break the rule on the stream it has actually sent so far. If it would, a 1 is sent instead; otherwise the input bit passes unchanged. Each accepted input bit appears on the registered output after the clock edge that takes it. The outgoing flag always judges the unrepaired input stream, so it reports what the source produced. Enforcement should be left off for line codes that already guarantee density by substitution.

Top module: `pd_guard`

## Requirements
- R1: While reset is asserted and directly after it, `tx_viol_o`, `rx_viol_o` and `tx_bit_o` are 0.
- R2: A stream whose accepted bits since reset end in 16 consecutive zeros sets its flag at the edge that takes the 16th zero. A run of 15 zeros does not set it.
- R3: A stream sets its flag at the edge that takes a bit completing a window of 8·(N+1) bits, for any N in 1..23, with fewer than N ones. Streams that meet every window leave the flag at 0.
- R4: A window of length L is judged only once at least L bits have been accepted on that stream since reset.
- R5: The outgoing flag judges `tx_bit_i` as presented, before any repair, whether or not enforcement is on.
- R6: Each stream has its own history and its own flag. Activity or breaches on one stream never move the other stream's flag.
- R7: Flags are sticky. A `clear_i` pulse returns a flag to 0 at the next edge, unless that stream breaches the rule in the same cycle; then the flag ends up 1.
- R8: With `enforce_en_i` low, `tx_bit_o` takes the value of `tx_bit_i` at each edge where `tx_valid_i` is high.
- R9: With `enforce_en_i` high, `tx_bit_o` is 1 when `tx_bit_i` is 1 or when appending a 0 to the sent stream would break the run limit or any judged window. Otherwise it is 0. If enforcement stays on from reset, the sent stream never holds more than 15 zeros in a row.
- R10: When a bit-valid strobe is low, that stream's history does not change. On the outgoing side, `tx_bit_o` also holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_valid_i | input | 1 | Outgoing bit strobe |
| tx_bit_i | input | 1 | Outgoing bit before repair |
| rx_valid_i | input | 1 | Incoming bit strobe |
| rx_bit_i | input | 1 | Incoming bit |
| enforce_en_i | input | 1 | Turns repair of the outgoing stream on |
| clear_i | input | 1 | One-cycle pulse that clears both flags |
| tx_bit_o | output | 1 | Outgoing bit after repair, registered |
| tx_viol_o | output | 1 | Sticky breach flag for the outgoing input stream |
| rx_viol_o | output | 1 | Sticky breach flag for the incoming stream |

## Verification
The bench drives several input patterns and each one separates a different part of the rule:
- Pure zero runs of 15 and 16 bits probe the run limit at its edge.
- A sparse 1-in-15 pattern keeps every run short but fails the 24-bit window, so it checks the window counts apart from the run limit.
- A 1-in-9 pattern only fails once the 80-bit window becomes judged, which pins down start-up gating.
- A 1-in-8 pattern meets every window and must never raise a flag.
- Random sparse streams with gapped strobes and enforcement toggled part-way exercise repair, hold behaviour and clear priority.

In every case, outputs are compared each cycle against a behavioural model that counts ones in explicit bit queues.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned PD_N_MAX   = 23;  // windows N = 1..N_MAX
  localparam int unsigned PD_SLOT    = 8;   // window length = SLOT*(N+1)
  localparam int unsigned PD_RUN_MAX = 15;  // longest legal zero run
endpackage

// File: rtl/pd_window_bank.sv
// History plus per-window running ones counts; flags a breach for one
// evaluated bit (the presented bit, or a hypothetical 0 when probing).
module pd_window_bank
  import pd_pkg::*;
#(
  parameter int unsigned N_MAX      = PD_N_MAX,
  parameter int unsigned SLOT       = PD_SLOT,
  parameter int unsigned RUN_MAX    = PD_RUN_MAX,
  parameter bit          PROBE_ZERO = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic bad_o
);
  localparam int unsigned W  = SLOT * (N_MAX + 1);
  localparam int unsigned CW = $clog2(W + 1);
  localparam int unsigned RW = $clog2(RUN_MAX + 2);

  logic [W-1:0]     hist_q;
  logic [CW-1:0]    fill_q;
  logic [RW-1:0]    run_q;
  logic             eval_bit;
  logic             run_bad;
  logic [N_MAX-1:0] win_bad;

  generate
    if (PROBE_ZERO) begin : g_probe
      assign eval_bit = 1'b0;
    end else begin : g_actual
      assign eval_bit = bit_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
      run_q  <= '0;
    end else if (valid_i) begin
      hist_q <= {hist_q[W-2:0], bit_i};
      if (fill_q != CW'(W)) fill_q <= fill_q + 1'b1;
      if (bit_i)                          run_q <= '0;
      else if (run_q != RW'(RUN_MAX + 1)) run_q <= run_q + 1'b1;
    end
  end

  assign run_bad = !eval_bit && (run_q >= RW'(RUN_MAX));

  for (genvar n = 1; n <= N_MAX; n++) begin : g_win
    localparam int unsigned L = SLOT * (n + 1);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] base;
    logic          armed;

    // ones in the newest L-1 bits (oldest bit of the window drops out)
    assign base    = cnt_q - CW'(hist_q[L-1]);
    assign armed   = fill_q >= CW'(L - 1);
    assign win_bad[n-1] = armed && ((base + CW'(eval_bit)) < CW'(n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      cnt_q <= '0;
      else if (valid_i) cnt_q <= base + CW'(bit_i);
    end
  end

  assign bad_o = run_bad | (|win_bad);
endmodule

// File: rtl/pd_sticky.sv
module pd_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/pd_enforcer.sv
// Tracks the stream actually sent; forces a 1 when a 0 would breach.
module pd_enforcer
  import pd_pkg::*;
#(
  parameter int unsigned N_MAX   = PD_N_MAX,
  parameter int unsigned SLOT    = PD_SLOT,
  parameter int unsigned RUN_MAX = PD_RUN_MAX
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  input  logic en_i,
  output logic bit_o
);
  logic zero_bad;
  logic out_bit;

  assign out_bit = bit_i | (en_i & zero_bad);

  pd_window_bank #(
    .N_MAX(N_MAX), .SLOT(SLOT), .RUN_MAX(RUN_MAX), .PROBE_ZERO(1'b1)
  ) u_sent (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .bit_i  (out_bit),
    .bad_o  (zero_bad)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bit_o <= 1'b0;
    else if (valid_i) bit_o <= out_bit;
  end
endmodule

// File: rtl/pd_guard.sv
module pd_guard
  import pd_pkg::*;
#(
  parameter int unsigned N_MAX   = PD_N_MAX,
  parameter int unsigned SLOT    = PD_SLOT,
  parameter int unsigned RUN_MAX = PD_RUN_MAX
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_valid_i,
  input  logic tx_bit_i,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  input  logic enforce_en_i,
  input  logic clear_i,
  output logic tx_bit_o,
  output logic tx_viol_o,
  output logic rx_viol_o
);
  logic tx_bad, rx_bad;

  pd_window_bank #(
    .N_MAX(N_MAX), .SLOT(SLOT), .RUN_MAX(RUN_MAX), .PROBE_ZERO(1'b0)
  ) u_tx_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(tx_valid_i),
    .bit_i  (tx_bit_i),
    .bad_o  (tx_bad)
  );

  pd_window_bank #(
    .N_MAX(N_MAX), .SLOT(SLOT), .RUN_MAX(RUN_MAX), .PROBE_ZERO(1'b0)
  ) u_rx_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(rx_valid_i),
    .bit_i  (rx_bit_i),
    .bad_o  (rx_bad)
  );

  pd_sticky u_tx_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (tx_valid_i & tx_bad),
    .clr_i (clear_i),
    .flag_o(tx_viol_o)
  );

  pd_sticky u_rx_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (rx_valid_i & rx_bad),
    .clr_i (clear_i),
    .flag_o(rx_viol_o)
  );

  pd_enforcer #(
    .N_MAX(N_MAX), .SLOT(SLOT), .RUN_MAX(RUN_MAX)
  ) u_enf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(tx_valid_i),
    .bit_i  (tx_bit_i),
    .en_i   (enforce_en_i),
    .bit_o  (tx_bit_o)
  );
endmodule

// File: rtl/pd_guard_chk.sv
module pd_guard_chk #(
  parameter int unsigned RUN_MAX = 15
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_valid_i,
  input logic tx_bit_i,
  input logic rx_valid_i,
  input logic enforce_en_i,
  input logic clear_i,
  input logic tx_bit_o,
  input logic tx_viol_o,
  input logic rx_viol_o
);
  localparam int unsigned RW = $clog2(RUN_MAX + 2);

  logic          v_q;
  logic          en_all_q;
  logic [RW-1:0] orun_q;

  // zero run on the sent stream while enforcement held since reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q      <= 1'b0;
      en_all_q <= 1'b1;
      orun_q   <= '0;
    end else begin
      v_q      <= tx_valid_i;
      en_all_q <= en_all_q & enforce_en_i;
      if (v_q) begin
        if (tx_bit_o)                        orun_q <= '0;
        else if (orun_q != RW'(RUN_MAX + 1)) orun_q <= orun_q + 1'b1;
      end
    end
  end

  assert_tx_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_viol_o && !clear_i |=> tx_viol_o);
  assert_rx_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_viol_o && !clear_i |=> rx_viol_o);
  assert_tx_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !tx_valid_i |=> !tx_viol_o);
  assert_rx_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !rx_valid_i |=> !rx_viol_o);
  assert_passthru_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && !enforce_en_i |=> tx_bit_o == $past(tx_bit_i));
  assert_ones_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_bit_i |=> tx_bit_o);
  assert_out_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_all_q |-> orun_q <= RW'(RUN_MAX));
  assert_tx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_i |=> $stable(tx_bit_o));
  assert_rx_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i && !rx_viol_o |=> !rx_viol_o);
endmodule

bind pd_guard pd_guard_chk #(.RUN_MAX(RUN_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_valid_i  (tx_valid_i),
  .tx_bit_i    (tx_bit_i),
  .rx_valid_i  (rx_valid_i),
  .enforce_en_i(enforce_en_i),
  .clear_i     (clear_i),
  .tx_bit_o    (tx_bit_o),
  .tx_viol_o   (tx_viol_o),
  .rx_viol_o   (rx_viol_o)
);

// File: tb/pd_guard_tb.sv
`timescale 1ns/1ps
module pd_guard_tb;
  localparam int N_MAX   = 23;
  localparam int SLOT    = 8;
  localparam int RUN_LIM = 15;
  localparam int KEEP    = 200;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_valid_i = 1'b0, tx_bit_i = 1'b0, rx_valid_i = 1'b0, rx_bit_i = 1'b0;
  logic enforce_en_i = 1'b0, clear_i = 1'b0;
  logic tx_bit_o, tx_viol_o, rx_viol_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  pd_guard u_dut (.*);

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string tag = "R1";

  // behavioural model state
  bit q_tx[$], q_rx[$], q_out[$];
  int n_tx, n_rx, n_out;
  bit e_txv, e_rxv, e_out;

  function automatic bit breaks(input bit q[$], input int seen, input bit b);
    int n = seen + 1;
    if (!b) begin
      int run = 1;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i]) break;
        run++;
      end
      if (run > RUN_LIM) return 1'b1;
    end
    for (int k = 1; k <= N_MAX; k++) begin
      int len = SLOT * (k + 1);
      int ones = b;
      if (n < len) continue;
      for (int i = 0; i < len - 1; i++) ones += q[q.size() - 1 - i];
      if (ones < k) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic push(ref bit q[$], ref int n, input bit b);
    q.push_back(b);
    if (q.size() > KEEP) void'(q.pop_front());
    n++;
  endtask

  task automatic model_reset();
    q_tx.delete(); q_rx.delete(); q_out.delete();
    n_tx = 0; n_rx = 0; n_out = 0;
    e_txv = 0; e_rxv = 0; e_out = 0;
  endtask

  task automatic chk(input string what, input logic got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got=%0b exp=%0b at cycle %0d", tag, what, got, exp, cyc);
    end
  endtask

  task automatic compare();
    chk("tx_viol_o", tx_viol_o, e_txv);
    chk("rx_viol_o", rx_viol_o, e_rxv);
    chk(enforce_en_i ? "tx_bit_o(R9)" : "tx_bit_o(R8)", tx_bit_o, e_out);
  endtask

  task automatic step(input bit tv, input bit tb, input bit rv, input bit rb,
                      input bit en, input bit clr);
    bit hit_t, hit_r;
    tx_valid_i = tv; tx_bit_i = tb; rx_valid_i = rv; rx_bit_i = rb;
    enforce_en_i = en; clear_i = clr;
    hit_t = tv && breaks(q_tx, n_tx, tb);
    hit_r = rv && breaks(q_rx, n_rx, rb);
    e_txv = hit_t ? 1'b1 : (clr ? 1'b0 : e_txv);
    e_rxv = hit_r ? 1'b1 : (clr ? 1'b0 : e_rxv);
    if (tv) begin
      bit o = tb | (en && breaks(q_out, n_out, 1'b0));
      e_out = o;
      push(q_out, n_out, o);
      push(q_tx, n_tx, tb);
    end
    if (rv) push(q_rx, n_rx, rb);
    @(posedge clk_i);
    @(negedge clk_i);
    compare();
  endtask

  task automatic do_reset();
    tag = "R1";
    @(negedge clk_i);
    rst_ni = 1'b0;
    tx_valid_i = 0; rx_valid_i = 0; clear_i = 0; enforce_en_i = 0;
    tx_bit_i = 0; rx_bit_i = 0;
    model_reset();
    repeat (2) @(negedge clk_i);
    compare();  // R1 during reset
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare();  // R1 after release
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired tx_viol_o=%0b exp=%0b", tx_viol_o, e_txv);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R2: 15 zeros on rx keep the flag low, the 16th sets it; tx idle (R10)
    tag = "R2";
    for (int i = 0; i < 15; i++) step(0, 0, 1, 0, 0, 0);
    chk("rx_viol_o after 15 zeros (R2)", rx_viol_o, 1'b0);
    step(0, 0, 1, 0, 0, 0);
    chk("rx_viol_o after 16 zeros (R2)", rx_viol_o, 1'b1);
    chk("tx_viol_o untouched (R6)", tx_viol_o, 1'b0);

    // R7: clear with no strobe
    tag = "R7";
    step(0, 0, 0, 0, 0, 1);
    chk("rx_viol_o cleared (R7)", rx_viol_o, 1'b0);

    // R3: 1-in-15 keeps runs short but breaks the 24-bit window
    tag = "R3";
    for (int i = 0; i < 60; i++) step(0, 0, 1, (i % 15) == 0, 0, (i % 7) == 3);
    // R7: clear held while the window keeps breaking
    tag = "R7";
    for (int i = 60; i < 90; i++) step(0, 0, 1, (i % 15) == 0, 0, 1);
    chk("rx_viol_o set despite clear (R7)", rx_viol_o, 1'b1);

    // R4 R5 R6 R8: 1-in-9 on both sides, flags only once 80 bits judged
    do_reset();
    tag = "R4 R5 R6";
    for (int i = 0; i < 78; i++) step(1, (i % 9) == 0, 1, (i % 9) == 0, 0, 0);
    chk("rx_viol_o before 80-bit window armed (R4)", rx_viol_o, 1'b0);
    for (int i = 78; i < 130; i++) step(1, (i % 9) == 0, 1, (i % 9) == 0, 0, 0);
    chk("rx_viol_o after 80-bit window armed (R4)", rx_viol_o, 1'b1);
    chk("tx_viol_o judges input (R5)", tx_viol_o, 1'b1);

    // R3 negative: 1-in-8 meets all windows once old bits age out
    do_reset();
    tag = "R3";
    for (int i = 0; i < 400; i++) step(1, (i % 8) == 7, 1, (i % 8) == 0, 0, 0);
    chk("rx_viol_o with 1-in-8 (R3)", rx_viol_o, 1'b0);
    chk("tx_viol_o with 1-in-8 (R3)", tx_viol_o, 1'b0);

    // R9 R10 R5: enforcement from reset, sparse input, gapped strobes
    do_reset();
    tag = "R9 R10 R5";
    for (int i = 0; i < 900; i++)
      step(($urandom % 4) != 0, ($urandom % 20) == 0,
           ($urandom % 3) != 0, ($urandom % 2) == 0, 1, 0);
    chk("tx_viol_o flags raw input under enforcement (R5)", tx_viol_o, e_txv);

    // R8 R6 R7: no enforcement, dense tx, zero rx, random clears
    tag = "R8 R6 R7";
    for (int i = 0; i < 300; i++)
      step(($urandom % 5) != 0, ($urandom % 2) == 0,
           ($urandom % 2) == 0, ($urandom % 30) == 0, 0, ($urandom % 25) == 0);

    // R9: enforcement toggled mid-stream with sparse input
    tag = "R9";
    for (int i = 0; i < 600; i++)
      step(($urandom % 3) != 0, ($urandom % 12) == 0,
           ($urandom % 2) == 0, ($urandom % 10) != 0,
           (i / 100) % 2 == 0, ($urandom % 40) == 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule